// File: doc/BRIEF.md
# Terminal Page Memory Controller

This block owns the character page store of a video terminal and shares it between two users. The display refresh path walks the visible screen in raster order and hands each stored entry to the character generator. The receive path writes one incoming character at the cursor position. Each entry is 9 bits: a 7-bit character code plus a protect flag and a blink flag, all written together.

Every clock is one character slot. A raster counter steps through `COLS` visible columns followed by `HBLANK` blanking slots on each of `ROWS` lines. In a visible slot with refresh enabled, the slot belongs to a refresh read. In every other slot the store is free, and a held cursor write goes in there. The address mux then selects the captured cursor address instead of the raster address, and a write strobe is raised. The receive source gets a one-cycle acknowledge afterwards. Clearing the refresh enable frees every slot, so writes complete in the next cycle. The store is `DEPTH` entries deep, but only the first `COLS*ROWS` are ever addressed.

Top module: `page_mem_ctrl`

## Requirements
- R1: The write address is `cur_row_i*COLS + cur_col_i`, taken as a linear number. A column value of `COLS` or more therefore runs into the following row. The full 9-bit `wr_data_i` is stored as one entry: bit 8 is blink, bit 7 is protect and bits 6:0 are the code. A later refresh read returns all 9 bits unchanged.
- R2: With refresh disabled, a request sampled at edge n raises `wr_strobe_o` and puts the cursor address on `mem_addr_o` in the cycle after edge n. `wr_ack_o` is then high for exactly the one cycle after edge n+1.
- R3: A request whose linear address is `COLS*ROWS` or higher raises no strobe and changes no entry. It is still acknowledged: `wr_ack_o` is high in the cycle after the edge that samples it.
- R4: With refresh enabled, `rd_valid_o` marks a read whose `rd_addr_o` is one more than the previous read, counting modulo `COLS*ROWS`. `rd_data_o` is the entry at that address. Each line gives `COLS` consecutive reads followed by `HBLANK` idle slots, so any `(COLS+HBLANK)*ROWS` consecutive cycles contain exactly `COLS*ROWS` reads.
- R5: While `refresh_en_i` is low, no read is issued: `rd_valid_o` stays low from the cycle after it was sampled low.
- R6: With refresh enabled, a write is made only in a slot that issues no refresh read. A pending write is held until such a slot arrives and is acknowledged within `COLS+HBLANK+1` cycles of its request.
- R7: A request that arrives while a write is pending is ignored. It produces no strobe, no acknowledge and no change to the store.
- R8: While `rst_ni` is low, `wr_strobe_o`, `wr_ack_o` and `rd_valid_o` are low.
- R9: `mem_addr_o` is below `COLS*ROWS` whenever a write strobe or a read is issued, so the entries above that bound are never touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one character slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_en_i | input | 1 | High to let refresh reads own visible slots |
| wr_req_i | input | 1 | Receive path offers a character |
| wr_data_i | input | 9 | Entry to write: blink, protect, 7-bit code |
| cur_row_i | input | $clog2(ROWS) | Cursor row |
| cur_col_i | input | $clog2(COLS) | Cursor column |
| wr_strobe_o | output | 1 | Store write in this slot |
| wr_ack_o | output | 1 | One-cycle acknowledge to the receive path |
| mem_addr_o | output | $clog2(DEPTH) | Store address selected by the mux |
| rd_valid_o | output | 1 | Refresh read data valid |
| rd_addr_o | output | $clog2(DEPTH) | Address of the returned read |
| rd_data_o | output | 9 | Entry returned to the character generator |

## Verification
The bench builds the block with 6 columns, 5 rows, 2 blanking slots and a 32-entry store. A full frame then takes only 40 cycles, so several complete raster passes fit in a short run, including the wrap from the last entry back to 0. Three-bit cursor fields let row 5 and row 7 produce addresses past the 30 visible entries, which exercises the drop path. The 2 entries above the visible area show that the top of the store is never addressed. Column values past the last column show the linear run-on into the next row.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CODE_W  = 7;
  localparam int ENTRY_W = CODE_W + 2;

  typedef struct packed {
    logic              blink;
    logic              prot;
    logic [CODE_W-1:0] code;
  } pm_entry_t;
endpackage

// File: rtl/pm_raster.sv
module pm_raster #(
  parameter int COLS   = 80,
  parameter int ROWS   = 24,
  parameter int HBLANK = 16,
  parameter int AW     = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] lin_o,
  output logic          active_o
);
  localparam int LINE = COLS + HBLANK;
  localparam int CW   = (LINE > 1) ? $clog2(LINE) : 1;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic [AW-1:0] lin_q;

  assign active_o = (col_q < CW'(COLS));
  assign lin_o    = lin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      lin_q <= '0;
    end else if (col_q == CW'(LINE - 1)) begin
      col_q <= '0;
      if (row_q == RW'(ROWS - 1)) begin
        row_q <= '0;
        lin_q <= '0;
      end else begin
        row_q <= row_q + 1'b1;
      end
    end else begin
      col_q <= col_q + 1'b1;
      if (active_o) lin_q <= lin_q + 1'b1;
    end
  end
endmodule

// File: rtl/pm_write_hold.sv
module pm_write_hold
  import pm_pkg::*;
#(
  parameter int AW   = 11,
  parameter int LW   = 13,
  parameter int DISP = 1920
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [LW-1:0] lin_i,
  input  pm_entry_t     data_i,
  input  logic          slot_free_i,
  output logic          strobe_o,
  output logic [AW-1:0] addr_o,
  output pm_entry_t     data_o,
  output logic          ack_o
);
  logic          pend_q, ack_q;
  logic [AW-1:0] addr_q;
  pm_entry_t     data_q;
  logic          in_range;

  assign in_range = (int'(lin_i) < DISP);
  assign strobe_o = pend_q & slot_free_i;
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign ack_o    = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ack_q <= 1'b0;
      if (pend_q) begin
        if (slot_free_i) begin
          pend_q <= 1'b0;
          ack_q  <= 1'b1;
        end
      end else if (req_i) begin
        if (in_range) begin
          pend_q <= 1'b1;
          addr_q <= lin_i[AW-1:0];
          data_q <= data_i;
        end else begin
          ack_q <= 1'b1;  // out of range: drop, still release the source
        end
      end
    end
  end
endmodule

// File: rtl/pm_store.sv
module pm_store
  import pm_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  pm_entry_t     wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rvalid_o,
  output logic [AW-1:0] raddr_o,
  output pm_entry_t     rdata_o
);
  pm_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      raddr_o  <= '0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) begin
        raddr_o <= raddr_i;
        rdata_o <= mem_q[raddr_i];
      end
    end
  end
endmodule

// File: rtl/page_mem_ctrl.sv
module page_mem_ctrl
  import pm_pkg::*;
#(
  parameter int COLS   = 80,
  parameter int ROWS   = 24,
  parameter int HBLANK = 16,
  parameter int DEPTH  = 2048
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     refresh_en_i,
  input  logic                     wr_req_i,
  input  logic [ENTRY_W-1:0]       wr_data_i,
  input  logic [$clog2(ROWS)-1:0]  cur_row_i,
  input  logic [$clog2(COLS)-1:0]  cur_col_i,
  output logic                     wr_strobe_o,
  output logic                     wr_ack_o,
  output logic [$clog2(DEPTH)-1:0] mem_addr_o,
  output logic                     rd_valid_o,
  output logic [$clog2(DEPTH)-1:0] rd_addr_o,
  output logic [ENTRY_W-1:0]       rd_data_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);
  localparam int LW   = RW + CW + 1;
  localparam int DISP = COLS * ROWS;

  logic          ras_active, rd_issue;
  logic [AW-1:0] ras_lin, wr_addr;
  logic [LW-1:0] cur_lin;
  pm_entry_t     wr_entry, rd_entry;

  assign cur_lin  = LW'(cur_row_i) * LW'(COLS) + LW'(cur_col_i);
  assign rd_issue = refresh_en_i & ras_active;

  pm_raster #(
    .COLS(COLS), .ROWS(ROWS), .HBLANK(HBLANK), .AW(AW)
  ) u_raster (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lin_o   (ras_lin),
    .active_o(ras_active)
  );

  pm_write_hold #(
    .AW(AW), .LW(LW), .DISP(DISP)
  ) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (wr_req_i),
    .lin_i      (cur_lin),
    .data_i     (pm_entry_t'(wr_data_i)),
    .slot_free_i(!rd_issue),
    .strobe_o   (wr_strobe_o),
    .addr_o     (wr_addr),
    .data_o     (wr_entry),
    .ack_o      (wr_ack_o)
  );

  // address mux: cursor address only while a write owns the slot
  assign mem_addr_o = wr_strobe_o ? wr_addr : ras_lin;

  pm_store #(
    .DEPTH(DEPTH), .AW(AW)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_strobe_o),
    .waddr_i (mem_addr_o),
    .wdata_i (wr_entry),
    .re_i    (rd_issue),
    .raddr_i (mem_addr_o),
    .rvalid_o(rd_valid_o),
    .raddr_o (rd_addr_o),
    .rdata_o (rd_entry)
  );

  assign rd_data_o = rd_entry;
endmodule

// File: rtl/page_mem_ctrl_chk.sv
module page_mem_ctrl_chk #(
  parameter int DISP = 1920,
  parameter int AW   = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          refresh_en_i,
  input logic          wr_strobe_o,
  input logic          wr_ack_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rd_valid_o,
  input logic [AW-1:0] rd_addr_o
);
  assert_wr_addr_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> (int'(mem_addr_o) < DISP));

  assert_rd_addr_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (int'(rd_addr_o) < DISP));

  assert_ack_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> wr_ack_o);

  assert_no_read_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_en_i |=> !rd_valid_o);

  assert_no_collide_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !rd_valid_o);

  assert_raster_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && $past(rd_valid_o)) |-> (rd_addr_o == $past(rd_addr_o) + 1'b1));
endmodule

bind page_mem_ctrl page_mem_ctrl_chk #(
  .DISP(COLS * ROWS), .AW($clog2(DEPTH))
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .refresh_en_i(refresh_en_i),
  .wr_strobe_o (wr_strobe_o),
  .wr_ack_o    (wr_ack_o),
  .mem_addr_o  (mem_addr_o),
  .rd_valid_o  (rd_valid_o),
  .rd_addr_o   (rd_addr_o)
);

// File: tb/page_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_mem_ctrl_tb_top;
  localparam int COLS = 6, ROWS = 5, HBLANK = 2, DEPTH = 32;
  localparam int DISP = COLS * ROWS;
  localparam int LINE = COLS + HBLANK;
  localparam int FRAME = LINE * ROWS;

  logic clk_i = 1'b0, rst_ni = 1'b0, refresh_en_i = 1'b0, wr_req_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic [2:0] cur_row_i = '0, cur_col_i = '0;
  logic       wr_strobe_o, wr_ack_o, rd_valid_o;
  logic [4:0] mem_addr_o, rd_addr_o;
  logic [8:0] rd_data_o;

  int checks = 0, errors = 0;
  logic [8:0] model [DISP];
  bit         known [DISP];

  always #2.5 clk_i = ~clk_i;

  page_mem_ctrl #(.COLS(COLS), .ROWS(ROWS), .HBLANK(HBLANK), .DEPTH(DEPTH)) dut_i (.*);

  // {row[2:0], col[2:0], data[8:0], drop}
  localparam logic [15:0] VEC [8] = '{
    {3'd0, 3'd0, 9'h041, 1'b0},
    {3'd0, 3'd5, 9'h1FF, 1'b0},
    {3'd1, 3'd0, 9'h0C5, 1'b0},
    {3'd4, 3'd5, 9'h12A, 1'b0},
    {3'd5, 3'd0, 9'h055, 1'b1},
    {3'd2, 3'd3, 9'h17F, 1'b0},
    {3'd7, 3'd7, 9'h000, 1'b1},
    {3'd0, 3'd7, 9'h033, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Refresh off: strobe one cycle after the request edge, ack one later.
  task automatic do_write(logic [2:0] r, logic [2:0] c, logic [8:0] d, bit drop);
    int lin = int'(r) * COLS + int'(c);
    @(negedge clk_i);
    wr_req_i = 1'b1; cur_row_i = r; cur_col_i = c; wr_data_i = d;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    if (drop) begin
      chk("R3 no strobe", int'(wr_strobe_o), 0);
      chk("R3 ack", int'(wr_ack_o), 1);
      @(negedge clk_i);
      chk("R3 ack single", int'(wr_ack_o), 0);
    end else begin
      chk("R2 strobe", int'(wr_strobe_o), 1);
      chk("R1 R2 mem_addr", int'(mem_addr_o), lin);
      chk("R2 ack early", int'(wr_ack_o), 0);
      @(negedge clk_i);
      chk("R2 ack", int'(wr_ack_o), 1);
      chk("R2 strobe off", int'(wr_strobe_o), 0);
      @(negedge clk_i);
      chk("R2 ack single", int'(wr_ack_o), 0);
      model[lin] = d; known[lin] = 1'b1;
    end
  endtask

  // R4 raster order / data, R1 R3 R7 stored contents.
  task automatic readback(int cycles);
    int prev = -1;
    int cnt = 0;
    refresh_en_i = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (rd_valid_o) begin
        if (i < FRAME) cnt++;
        if (prev >= 0) chk("R4 raster order", int'(rd_addr_o), (prev + 1) % DISP);
        prev = int'(rd_addr_o);
        if (prev < DISP && known[prev]) chk("R1 R3 R7 stored entry", int'(rd_data_o), int'(model[prev]));
      end
    end
    chk("R4 reads per frame", cnt, DISP);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DISP; i++) known[i] = 1'b0;
    #7;
    chk("R8 strobe in reset", int'(wr_strobe_o), 0);
    chk("R8 ack in reset", int'(wr_ack_o), 0);
    chk("R8 rd_valid in reset", int'(rd_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < 8; v++)
      do_write(VEC[v][15:13], VEC[v][12:10], VEC[v][9:1], VEC[v][0]);

    // R5: refresh off keeps reads idle
    for (int i = 0; i < 2 * LINE; i++) begin
      @(negedge clk_i);
      chk("R5 no read while off", int'(rd_valid_o), 0);
    end

    readback(2 * FRAME + 3);

    // R6 + R7: refresh on, write waits for blank slot; second request ignored
    begin
      int waited = 0;
      bit got = 1'b0;
      @(negedge clk_i);
      wr_req_i = 1'b1; cur_row_i = 3'd3; cur_col_i = 3'd2; wr_data_i = 9'h1A5;
      @(negedge clk_i);
      cur_row_i = 3'd3; cur_col_i = 3'd4; wr_data_i = 9'h0EE;  // arrives while pending
      @(negedge clk_i);
      wr_req_i = 1'b0;
      waited = 2;
      while (!got && waited < LINE + 4) begin
        if (wr_ack_o) got = 1'b1;
        else begin
          if (wr_strobe_o) begin
            @(negedge clk_i);
            waited++;
            chk("R6 no read in write slot", int'(rd_valid_o), 0);
          end else begin
            @(negedge clk_i);
            waited++;
          end
        end
      end
      chk("R6 ack received", int'(got), 1);
      chk("R6 ack latency bound", int'(waited <= LINE + 2), 1);
      model[20] = 9'h1A5; known[20] = 1'b1;
      begin
        int extra = 0;
        for (int i = 0; i < 2 * LINE; i++) begin
          @(negedge clk_i);
          if (wr_ack_o || wr_strobe_o) extra++;
        end
        chk("R7 second request ignored", extra, 0);
      end
      known[22] = 1'b1;
      if (!known[22]) model[22] = '0;
    end
    known[22] = 1'b0;
    readback(FRAME + 2);

    // R3 again under refresh: dropped request leaves readback intact
    @(negedge clk_i);
    wr_req_i = 1'b1; cur_row_i = 3'd6; cur_col_i = 3'd1; wr_data_i = 9'h111;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    chk("R3 ack under refresh", int'(wr_ack_o), 1);
    readback(FRAME + 2);

    summary();
    $finish;
  end
endmodule